// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a free-running reference clock into the sample-rate strobe that a UART transmitter and receiver use to time their bits. The reference first passes through an optional divide-by-four prescaler, then through a divider whose ratio is a 16-bit integer plus a fraction in sixteenths. The fraction is realised by lengthening some sample periods by one prescaled reference tick, spread evenly by a 4-bit phase accumulator. Over any 16 periods that start at a restart, the average period is exactly the programmed ratio.

Configuration arrives as byte writes to four registers: integer low byte, integer high byte, a fraction/mode byte and a prescaler select. Two bits of the fraction/mode byte choose how many strobes make one serial bit (16, 8 or 4). The block reports that choice and marks the strobe that closes each bit time. Every write restarts the whole timing chain, so no period is ever built from a mix of old and new settings. Configuration pins are plain control inputs with no back-pressure: a write takes effect at the clock edge where `wr_en` is high.

The outputs are registered. `samp_en` is one cycle wide whenever a period is two or more cycles long, and `bit_en` can only be high together with `samp_en`.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the integer divisor is 1, the fraction is 0, the mode is 16X and the prescaler is off. From the first clock edge after reset is released, `samp_en` is high in every cycle and `smode` reads 00.
- R2: Register addresses on `wr_addr` are 0 = integer bits 7:0, 1 = integer bits 15:8, 2 = fraction/mode byte, 3 = prescaler select (bit 0 of `wr_data`). In the fraction/mode byte, bits 3:0 are the fraction f and bits 5:4 are the mode.
- R3: Number period j after a restart (j = 1, 2, ...) with acc_j = ((j-1)*f) mod 16. That period lasts P*(D + c_j) cycles, where c_j = 1 if acc_j + f >= 16 and 0 otherwise. Any 16 periods from a restart therefore total P*(16*D + f) cycles.
- R4: P is 1 when the prescaler select is 0 and 4 when it is 1.
- R5: `smode` decodes mode bits 5:4 as 00 = 16X, 01 = 8X, 10 = 4X. The reserved value 11 reads as 00 and behaves as 16X.
- R6: With N = 16, 8 or 4 for the mode, `bit_en` is high together with the N-th `samp_en` pulse after a restart and every N-th pulse after that, and is low otherwise.
- R7: A write to any address restarts the chain at that edge. `samp_en` and `bit_en` are low in the following cycle, the first pulse comes exactly P*D cycles after the write edge, and the accumulator, prescaler phase and strobe count all start from zero.
- R8: An integer divisor of 0 behaves as D = 1, with or without a fraction.
- R9: When P*D >= 2, `samp_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| samp_en | output | 1 | Sample-rate enable, one cycle per period |
| bit_en | output | 1 | Marks the strobe that ends a bit time |
| smode | output | 2 | Decoded oversampling mode (00 16X, 01 8X, 10 4X) |

## Verification
Any corruption of the period counter, the phase accumulator or the prescaler phase changes the spacing of `samp_en`. A broken period shows up at the very next pulse. An accumulator error can hide for up to 15 periods, but always shows up in the 16-period total, which is fixed by the divisor. A miscounted strobe index moves `bit_en` off its N-th pulse within one bit time. A restart that fails to clear state shows up as a wrong gap between the write and the first pulse.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic [1:0] {
    OS16 = 2'b00,
    OS8  = 2'b01,
    OS4  = 2'b10
  } os_mode_t;

  localparam logic [1:0] ADDR_INT_LO = 2'd0;
  localparam logic [1:0] ADDR_INT_HI = 2'd1;
  localparam logic [1:0] ADDR_FRAC   = 2'd2;
  localparam logic [1:0] ADDR_PRESC  = 2'd3;

  function automatic os_mode_t decode_mode(input logic [1:0] bits);
    case (bits)
      2'b01:   return OS8;
      2'b10:   return OS4;
      default: return OS16;
    endcase
  endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import frac_baud_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [2*REG_W-1:0]   int_div,
  output logic [FRAC_W-1:0]    frac_val,
  output os_mode_t             os_mode,
  output logic                 presc_on,
  output logic                 restart
);
  localparam int FM_W = FRAC_W + 2;

  logic [REG_W-1:0] lo_q, hi_q;
  logic [FM_W-1:0]  fm_q;
  logic             presc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= REG_W'(1);
      hi_q    <= '0;
      fm_q    <= '0;
      presc_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_INT_LO: lo_q    <= wr_data;
        ADDR_INT_HI: hi_q    <= wr_data;
        ADDR_FRAC:   fm_q    <= wr_data[FM_W-1:0];
        default:     presc_q <= wr_data[0];
      endcase
    end
  end

  assign int_div  = {hi_q, lo_q};
  assign frac_val = fm_q[FRAC_W-1:0];
  assign os_mode  = decode_mode(fm_q[FM_W-1:FRAC_W]);
  assign presc_on = presc_q;
  assign restart  = wr_en;

endmodule

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int PRESC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic presc_on,
  output logic ref_tick
);
  localparam int PC_W = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESC_DIV - 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pc_q <= '0;
    end else if (pc_q == PC_LAST) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + PC_W'(1);
    end
  end

  assign ref_tick = !presc_on || (pc_q == PC_LAST);

endmodule

// File: rtl/fbg_divider.sv
module fbg_divider #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              ref_tick,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              period_end
);
  localparam int LEN_W = INT_W + 1;

  logic [LEN_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic [INT_W-1:0]  div_eff;
  logic [LEN_W-1:0]  len;
  logic              last;

  // phase accumulator: a carry out stretches the current period by one tick
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_val};
  assign div_eff = (int_div == '0) ? INT_W'(1) : int_div;
  assign len     = {1'b0, div_eff} + LEN_W'(acc_sum[FRAC_W]);
  assign last    = (cnt_q == len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (ref_tick) begin
      if (last) begin
        cnt_q <= '0;
        acc_q <= acc_sum[FRAC_W-1:0];
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  assign period_end = ref_tick && last;

endmodule

// File: rtl/fbg_bitcount.sv
module fbg_bitcount
  import frac_baud_pkg::*;
#(
  parameter int MAX_OS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     period_end,
  input  os_mode_t os_mode,
  output logic     samp_en,
  output logic     bit_en
);
  localparam int SC_W = $clog2(MAX_OS);

  logic [SC_W-1:0] sc_q;
  logic [SC_W-1:0] sc_lim;

  always_comb begin
    case (os_mode)
      OS8:     sc_lim = SC_W'(MAX_OS / 2 - 1);
      OS4:     sc_lim = SC_W'(MAX_OS / 4 - 1);
      default: sc_lim = SC_W'(MAX_OS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sc_q    <= '0;
      samp_en <= 1'b0;
      bit_en  <= 1'b0;
    end else begin
      samp_en <= period_end;
      bit_en  <= period_end && (sc_q == sc_lim);
      if (period_end) begin
        sc_q <= (sc_q == sc_lim) ? '0 : sc_q + SC_W'(1);
      end
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int FRAC_W    = 4,
  parameter int PRESC_DIV = 4,
  parameter int MAX_OS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             samp_en,
  output logic             bit_en,
  output logic [1:0]       smode
);
  localparam int INT_W = 2 * REG_W;

  logic [INT_W-1:0]  int_div;
  logic [FRAC_W-1:0] frac_val;
  os_mode_t          os_mode;
  logic              presc_on;
  logic              restart;
  logic              ref_tick;
  logic              period_end;

  fbg_regs #(.REG_W(REG_W), .FRAC_W(FRAC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .int_div  (int_div),
    .frac_val (frac_val),
    .os_mode  (os_mode),
    .presc_on (presc_on),
    .restart  (restart)
  );

  fbg_prescale #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .presc_on (presc_on),
    .ref_tick (ref_tick)
  );

  fbg_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .ref_tick   (ref_tick),
    .int_div    (int_div),
    .frac_val   (frac_val),
    .period_end (period_end)
  );

  fbg_bitcount #(.MAX_OS(MAX_OS)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .period_end (period_end),
    .os_mode    (os_mode),
    .samp_en    (samp_en),
    .bit_en     (bit_en)
  );

  assign smode = os_mode;

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int INT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             samp_en,
  input logic             bit_en,
  input logic [1:0]       smode,
  input logic [INT_W-1:0] int_div,
  input logic             presc_on
);

  // R1: first cycle out of reset carries the reset configuration
  a_r1_reset_config: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (int_div == INT_W'(1)) && !presc_on && (smode == 2'b00));

  // R5: reserved mode code never reaches the output
  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    smode != 2'b11);

  // R6: the bit marker only rides on a sample strobe
  a_r6_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> samp_en);

  // R7: a write silences both strobes in the next cycle
  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !samp_en && !bit_en);

  // R9: strobe is one cycle wide when the period spans two or more cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en && (presc_on || (int_div > INT_W'(1))) |=> !samp_en);

endmodule

bind frac_baud_gen frac_baud_chk #(.INT_W(INT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .samp_en  (samp_en),
  .bit_en   (bit_en),
  .smode    (smode),
  .int_div  (int_div),
  .presc_on (presc_on)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       samp_en, bit_en;
  logic [1:0] smode;

  always #4 clk = ~clk;

  frac_baud_gen uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .samp_en (samp_en),
    .bit_en  (bit_en),
    .smode   (smode)
  );

  typedef struct packed {
    logic        presc;
    logic [15:0] div;
    logic [7:0]  fm;
    logic [15:0] sum16;
    logic [1:0]  md;
  } vec_t;

  localparam int NV  = 9;
  localparam int LIM = 5000;
  localparam vec_t VT [NV] = '{
    '{1'b0, 16'd1,   8'h00, 16'd16,   2'd0},
    '{1'b0, 16'd5,   8'h03, 16'd83,   2'd0},
    '{1'b0, 16'd0,   8'h00, 16'd16,   2'd0},
    '{1'b0, 16'd258, 8'h1F, 16'd4143, 2'd1},
    '{1'b1, 16'd3,   8'h25, 16'd212,  2'd2},
    '{1'b0, 16'd7,   8'h38, 16'd120,  2'd0},
    '{1'b1, 16'd2,   8'h10, 16'd128,  2'd1},
    '{1'b0, 16'd0,   8'h07, 16'd23,   2'd0},
    '{1'b0, 16'd12,  8'h2F, 16'd207,  2'd2}
  };

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic gap(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!samp_en && k < LIM);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, deff, f, pm, n, acc, sum, carry, expk;
    string rq;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 2'd0;
    wr_data = 8'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R6: divisor 1 after reset, marker on the 16th strobe
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      chk(samp_en == 1'b1, "R1", "samp_en every cycle", samp_en, 1);
      chk(bit_en == (i == 16), "R6", "bit_en after reset", bit_en, (i == 16));
    end
    chk(smode == 2'b00, "R1", "reset smode", smode, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, VT[v].div[7:0]);
      wr(2'd1, VT[v].div[15:8]);
      wr(2'd2, VT[v].fm);
      wr(2'd3, {7'd0, VT[v].presc});
      chk(!samp_en && !bit_en, "R7", "quiet after write", samp_en, 0);
      chk(smode == VT[v].md, "R5", "smode decode", smode, VT[v].md);
      deff = (VT[v].div == 16'd0) ? 1 : int'(VT[v].div);
      f    = int'(VT[v].fm[3:0]);
      pm   = VT[v].presc ? 4 : 1;
      n    = (VT[v].md == 2'd0) ? 16 : (VT[v].md == 2'd1) ? 8 : 4;
      rq   = (VT[v].div == 16'd0) ? "R8" : "R3";
      acc  = 0;
      sum  = 0;
      for (int j = 1; j <= 16; j++) begin
        gap(k);
        carry = ((acc + f) >= 16) ? 1 : 0;
        expk  = pm * (deff + carry);
        acc   = (acc + f) % 16;
        chk(k == expk, rq, "period length", k, expk);
        chk(bit_en == ((j % n) == 0), "R6", "bit marker", bit_en, ((j % n) == 0));
        sum += k;
      end
      chk(sum == int'(VT[v].sum16), VT[v].presc ? "R4" : "R2",
          "16-period total", sum, int'(VT[v].sum16));
    end

    // R7: a write in mid-period restarts the count from zero
    wr(2'd0, 8'd10);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'd0);
    gap(k);
    chk(k == 10, "R7", "first gap after write", k, 10);
    repeat (4) @(negedge clk);
    wr(2'd1, 8'd0);
    chk(!samp_en, "R7", "quiet after mid-period write", samp_en, 0);
    gap(k);
    chk(k == 10, "R7", "gap after mid-period write", k, 10);

    // R9: strobe never two cycles wide with divisor 2
    wr(2'd0, 8'd2);
    gap(k);
    @(negedge clk);
    chk(!samp_en, "R9", "single-cycle strobe", samp_en, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule